// File: doc/BRIEF.md
# Frame Pulse Format Converter

This block takes an 8 kHz frame pulse from a 2048 kbit/s TDM bus and works out which of two framing conventions it uses. The ST-BUS convention idles high and drops low across the frame boundary. The GCI convention idles low and rises at the start of timeslot 5. The block tells them apart by the level the pulse holds while idle. Its frame counters resynchronise to every pulse: they are preset to channel 0 for an ST-BUS pulse and to channel 5 for a GCI pulse. A frame is 512 clocks, made of 32 channels of 8 bits, with each bit lasting 2 clocks.

From the counters the block produces a frame pulse in the other convention. The output lands five channels after an ST-BUS input. For a GCI input it lands 27 channels after the pulse, which is five channels before the next one. A system that mixes the two kinds of component uses it as the framing bridge between them. It also uses the channel, bit and half-bit outputs to schedule per-timeslot work.

Top module: `fp_converter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the outputs read channel 0, bit 0, phase 0, `fmt_gci_o`=0 (0 = ST-BUS, 1 = GCI) and `fp_out`=0.
- R2: With no resynchronisation, the 9-bit position {channel, bit, phase} rises by one on every clock. The phase toggles every clock, the bit index advances every 2 clocks, and the channel advances every 16 clocks.
- R3: `fmt_gci_o` becomes 1 once `fp_in` has been sampled low on 5 consecutive clock edges. It becomes 0 once `fp_in` has been sampled high on 5 consecutive edges. A run of 4 or fewer samples at one level leaves it unchanged.
- R4: From channel 31, bit 7, phase 1 the counters wrap to channel 0, bit 0, phase 0 on the next clock.
- R5: The first clock edge on which `fp_in` is sampled at the active level of the current format loads the counters. The active level is low for ST-BUS and high for GCI. The counters become channel 0 for ST-BUS or channel 5 for GCI, with bit 0 and phase 0. This happens from any position, so the block is back in step within one frame.
- R6: When the format is ST-BUS, `fp_out` is a GCI pulse. It is high for exactly the one clock at channel 5, bit 0, phase 0 and low otherwise.
- R7: When the format is GCI, `fp_out` is an ST-BUS pulse. It is low for exactly the one clock at channel 31, bit 7, phase 1 and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_in | input | 1 | Incoming frame pulse, either convention |
| chan_o | output | 5 | Current channel number |
| bit_o | output | 3 | Bit index within the channel |
| phase_o | output | 1 | Half-bit phase, 0 = first clock of the bit |
| fmt_gci_o | output | 1 | Detected input format, 1 = GCI |
| fp_out | output | 1 | Frame pulse in the opposite format |

## Verification
A pulse sampled on a clock edge changes the counters on that same edge. After that the position rises by one on each later edge, so the bench counts the edges it steps past the load and checks each expected position at the falling edge that follows. The format flag changes on the fifth consecutive edge at one level. The bench therefore holds a level for eight edges before it reads the flag, and it reads a four-edge run just after that run ends. `fp_out` is decoded from registered state, so it is due in the same cycle as the position it marks, and the one-clock width is checked on both neighbouring cycles.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic {FMT_STBUS = 1'b0, FMT_GCI = 1'b1} fp_fmt_e;

  // Level that marks a pulse in the given input format.
  function automatic logic active_level(input fp_fmt_e f);
    return (f == FMT_GCI);
  endfunction

  // Channel the counters jump to when a pulse of format f is seen.
  function automatic int unsigned preset_chan(input fp_fmt_e f, input int unsigned offset);
    return (f == FMT_GCI) ? offset : 0;
  endfunction
endpackage

// File: rtl/fpc_fmt_detect.sv
module fpc_fmt_detect
  import fpc_pkg::*;
#(
  parameter int IDLE_RUN = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fp_i,
  output fp_fmt_e fmt_o,
  output logic    start_o
);
  localparam int RUN_W = $clog2(IDLE_RUN + 1);

  logic             fp_prev;
  logic [RUN_W-1:0] run_q, run_n;
  logic             long_run;

  always_comb begin
    if (fp_i != fp_prev)           run_n = RUN_W'(1);
    else if (run_q < RUN_W'(IDLE_RUN)) run_n = run_q + RUN_W'(1);
    else                           run_n = run_q;
  end

  assign long_run = (run_n >= RUN_W'(IDLE_RUN));
  assign start_o  = (fp_i == active_level(fmt_o)) && (fp_prev != active_level(fmt_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_prev <= 1'b1;
      run_q   <= '0;
      fmt_o   <= FMT_STBUS;
    end else begin
      fp_prev <= fp_i;
      run_q   <= run_n;
      if (long_run) fmt_o <= fp_i ? FMT_STBUS : FMT_GCI;
    end
  end

  // R3: a switch to GCI follows a low sample, a switch to ST-BUS a high one
  a_r3_gci_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_o == FMT_GCI && $past(fmt_o) == FMT_STBUS) |-> !$past(fp_i));
  a_r3_stbus_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_o == FMT_STBUS && $past(fmt_o) == FMT_GCI) |-> $past(fp_i));
endmodule

// File: rtl/fpc_slot_counter.sv
module fpc_slot_counter
  import fpc_pkg::*;
#(
  parameter int CH_W   = 5,
  parameter int BIT_W  = 3,
  parameter int OFFSET = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  fp_fmt_e          fmt_i,
  output logic [CH_W-1:0]  chan_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             phase_o
);
  localparam int POS_W = CH_W + BIT_W + 1;

  logic [POS_W-1:0] pos_q;
  logic [CH_W-1:0]  preset;

  assign preset = CH_W'(preset_chan(fmt_i, OFFSET));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (load_i) pos_q <= {preset, {(BIT_W+1){1'b0}}};
    else             pos_q <= pos_q + POS_W'(1);
  end

  assign chan_o  = pos_q[POS_W-1 -: CH_W];
  assign bit_o   = pos_q[BIT_W:1];
  assign phase_o = pos_q[0];

  // R2: free-running advance by one position per clock
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> {chan_o, bit_o, phase_o} == POS_W'($past({chan_o, bit_o, phase_o}) + POS_W'(1)));
  // R4: last clock of the frame wraps to the first
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && chan_o == '1 && bit_o == '1 && phase_o) |=> (chan_o == '0 && bit_o == '0 && !phase_o));
  // R5: a load lands on the preset channel at bit 0, phase 0
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (chan_o == $past(preset) && bit_o == '0 && !phase_o));
endmodule

// File: rtl/fpc_pulse_gen.sv
module fpc_pulse_gen
  import fpc_pkg::*;
#(
  parameter int CH_W   = 5,
  parameter int BIT_W  = 3,
  parameter int OFFSET = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fp_fmt_e          fmt_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic             phase_i,
  output logic             fp_o
);
  logic at_gci_slot, at_frame_end;

  assign at_gci_slot  = (chan_i == CH_W'(OFFSET)) && (bit_i == '0) && !phase_i;
  assign at_frame_end = (chan_i == '1) && (bit_i == '1) && phase_i;

  // ST-BUS input -> GCI output (idle low); GCI input -> ST-BUS output (idle high)
  assign fp_o = (fmt_i == FMT_STBUS) ? at_gci_slot : !at_frame_end;

  // R6: GCI-style output pulse lasts a single clock
  a_r6_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_i == FMT_STBUS && fp_o) |=> (!fp_o || fmt_i != FMT_STBUS));
  // R7: ST-BUS-style output pulse lasts a single clock
  a_r7_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_i == FMT_GCI && !fp_o) |=> (fp_o || fmt_i != FMT_GCI));
endmodule

// File: rtl/fp_converter.sv
module fp_converter
  import fpc_pkg::*;
#(
  parameter int CH_W     = 5,
  parameter int BIT_W    = 3,
  parameter int OFFSET   = 5,
  parameter int IDLE_RUN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_in,
  output logic [CH_W-1:0]  chan_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             phase_o,
  output logic             fmt_gci_o,
  output logic             fp_out
);
  fp_fmt_e fmt;
  logic    start;

  fpc_fmt_detect #(.IDLE_RUN(IDLE_RUN)) u_detect (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_in), .fmt_o(fmt), .start_o(start)
  );

  fpc_slot_counter #(.CH_W(CH_W), .BIT_W(BIT_W), .OFFSET(OFFSET)) u_count (
    .clk(clk), .rst_n(rst_n), .load_i(start), .fmt_i(fmt),
    .chan_o(chan_o), .bit_o(bit_o), .phase_o(phase_o)
  );

  fpc_pulse_gen #(.CH_W(CH_W), .BIT_W(BIT_W), .OFFSET(OFFSET)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt),
    .chan_i(chan_o), .bit_i(bit_o), .phase_i(phase_o), .fp_o(fp_out)
  );

  assign fmt_gci_o = (fmt == FMT_GCI);

  // R1: outputs sit at their reset values while reset is held
  a_r1_reset: assert property (@(posedge clk)
    !rst_n |-> (chan_o == '0 && bit_o == '0 && !phase_o && !fmt_gci_o && !fp_out));
endmodule

// File: tb/fp_converter_tb.sv
`timescale 1ns/1ps
module fp_converter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fp_in = 1'b1;
  logic [4:0] chan_o;
  logic [2:0] bit_o;
  logic       phase_o, fmt_gci_o, fp_out;

  int errors = 0;
  int checks = 0;
  int e = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp_converter u_dut (
    .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .chan_o(chan_o), .bit_o(bit_o),
    .phase_o(phase_o), .fmt_gci_o(fmt_gci_o), .fp_out(fp_out)
  );

  // {edges after load [19:10], channel [9:5], bit [4:2], phase [1], fp_out [0]}
  localparam logic [19:0] ST_TAB [0:9] = '{
    {10'd0,   5'd0,  3'd0, 1'b0, 1'b0},
    {10'd1,   5'd0,  3'd0, 1'b1, 1'b0},
    {10'd2,   5'd0,  3'd1, 1'b0, 1'b0},
    {10'd15,  5'd0,  3'd7, 1'b1, 1'b0},
    {10'd16,  5'd1,  3'd0, 1'b0, 1'b0},
    {10'd79,  5'd4,  3'd7, 1'b1, 1'b0},
    {10'd80,  5'd5,  3'd0, 1'b0, 1'b1},
    {10'd81,  5'd5,  3'd0, 1'b1, 1'b0},
    {10'd511, 5'd31, 3'd7, 1'b1, 1'b0},
    {10'd512, 5'd0,  3'd0, 1'b0, 1'b0}
  };
  localparam logic [19:0] GCI_TAB [0:5] = '{
    {10'd0,   5'd5,  3'd0, 1'b0, 1'b1},
    {10'd1,   5'd5,  3'd0, 1'b1, 1'b1},
    {10'd430, 5'd31, 3'd7, 1'b0, 1'b1},
    {10'd431, 5'd31, 3'd7, 1'b1, 1'b0},
    {10'd432, 5'd0,  3'd0, 1'b0, 1'b1},
    {10'd512, 5'd5,  3'd0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); e++;
  endtask

  task automatic walk_to(input int t);
    while (e < t) step();
  endtask

  task automatic check_entry(input string req, input logic [19:0] v);
    walk_to(int'(v[19:10]));
    chk({req, " chan"},  chan_o,  v[9:5]);
    chk({req, " bit"},   bit_o,   v[4:2]);
    chk({req, " phase"}, phase_o, v[1]);
    chk({req, " fp_out"}, fp_out, v[0]);
  endtask

  // One-clock pulse at the active level; leaves e=0 at the negedge after the load edge
  task automatic pulse(input logic act);
    @(negedge clk); fp_in = act;
    @(posedge clk); @(negedge clk); fp_in = ~act;
    e = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: values during reset
    @(negedge clk);
    chk("R1 chan in reset", chan_o, 0);
    chk("R1 fp_out in reset", fp_out, 0);
    rst_n = 1'b1;
    chk("R1 chan", chan_o, 0);
    chk("R1 bit", bit_o, 0);
    chk("R1 phase", phase_o, 0);
    chk("R1 fmt", fmt_gci_o, 0);
    chk("R1 fp_out", fp_out, 0);
    repeat (10) @(negedge clk);

    // R2 R4 R5 R6: ST-BUS input, walk a full frame and the wrap
    pulse(1'b0);
    foreach (ST_TAB[i]) check_entry("R2/R4/R6 stbus", ST_TAB[i]);
    chk("R3 fmt stays stbus", fmt_gci_o, 0);

    // R5: resync from mid-frame
    walk_to(200);
    pulse(1'b0);
    chk("R5 resync chan", chan_o, 0);
    chk("R5 resync bit", bit_o, 0);
    chk("R5 resync phase", phase_o, 0);

    // R3: four low samples do not change the format
    @(negedge clk); fp_in = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); fp_in = 1'b1;
    chk("R3 short low run fmt", fmt_gci_o, 0);
    chk("R5 load on first low chan", chan_o, 0);
    chk("R5 load on first low bit", bit_o, 1);
    chk("R5 load on first low phase", phase_o, 1);
    repeat (6) @(negedge clk);

    // R3: long low idle selects GCI
    fp_in = 1'b0;
    repeat (8) @(negedge clk);
    chk("R3 low idle fmt", fmt_gci_o, 1);

    // R5 R7: GCI input, preset 5, ST-BUS pulse at frame end
    pulse(1'b1);
    foreach (GCI_TAB[i]) check_entry("R5/R7 gci", GCI_TAB[i]);

    // R3: long high idle returns to ST-BUS
    fp_in = 1'b1;
    repeat (8) @(negedge clk);
    chk("R3 high idle fmt", fmt_gci_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule